// File: doc/BRIEF.md
# Mimic Path Phase Tracking Sequencer

This controller keeps a read-capture clock aligned with the data as voltage and temperature drift. It calibrates first and then keeps tracking. In each measurement sweep it takes one sample of a mimic-path signal at every phase tap of a measure clock. After each sample it asks the PLL to move the measure clock up by one tap. After one full circle of taps the measure clock is back where the sweep started. The controller then locates the centre of the longest circular run of high samples.

The first sweep with a usable result stores that centre as the reference and declares calibration complete. Later sweeps run on a fixed interval, nominally 128 ms, whose length in cycles is a parameter so that simulation can shorten it. When a later centre has moved from the reference, the controller steps the resynchronization clock by the same drift, taking the shorter way round the tap circle. No read or write traffic passes through the block. Its only effect is on clock phases.

The PLL phase-step port is a valid/ready channel that carries one step per transfer. The controller raises `step_valid` together with `step_up` and `step_sel`. It holds all three unchanged until the PLL accepts the step by driving `step_ready` high in the same cycle. The PLL may hold `step_ready` low for any number of cycles, and the controller simply waits. Only one step is ever outstanding. A measure step is followed by a sample, and a resync step is followed by the next resync step or by the interval wait.

Top module: `mimic_track_seq`

## Requirements
- R1: While reset is asserted and right after it, `step_valid`, `cal_done`, `sweep_done` and `sweep_err` are low and `rs_offset` is 0. The first sweep starts by itself once reset is released.
- R2: A sweep samples `mimic_bit` once at each of the NTAPS tap positions, and each sample is followed by exactly one accepted measure step (`step_sel`=0, `step_up`=1). A sweep therefore makes NTAPS measure steps and leaves the measure clock on the tap where it began.
- R3: While `step_valid` is high and `step_ready` is low, `step_valid`, `step_up` and `step_sel` keep their values.
- R4: Bit i of the sample set is the sample taken i measure steps after the sweep began. The sweep result is s + floor((L-1)/2) modulo NTAPS, where s is the first tap and L the length of the longest run of 1s, counted circularly so that a run may wrap from the last tap to tap 0.
- R5: The first sweep without error latches its result into `ref_phase`, raises `cal_done`, and issues no resync step. No resync step is ever issued while `cal_done` is low.
- R6: After a later sweep without error, let d = (result − reference − applied) mod NTAPS, where applied is the current `rs_offset`. If 0 < d ≤ NTAPS/2, the controller issues d resync steps up (`step_sel`=1, `step_up`=1). If d > NTAPS/2, it issues NTAPS − d resync steps down (`step_up`=0). `rs_offset` moves by +1 or −1 modulo NTAPS on each accepted resync step.
- R7: When d is 0, no resync step is issued and `rs_offset` keeps its value.
- R8: A sweep whose samples are all 0 or all 1 raises `sweep_err` alongside `sweep_done` and causes no resync step. If this happens during calibration, `cal_done` stays low and the next sweep calibrates again.
- R9: After a sweep that needs no correction, the first step request of the next sweep appears exactly INTERVAL + 1 cycles after the cycle in which `sweep_done` is high.
- R10: With KEEP_REF=1 (the default), `ref_phase` keeps its calibration value through every correction. With KEEP_REF=0, it takes each corrected sweep's result.
- R11: `sweep_done` is high for exactly one cycle per sweep. In that cycle `meas_phase` holds that sweep's result if `sweep_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mimic_bit | input | 1 | Mimic-path level as sampled by the measure clock |
| step_valid | output | 1 | Phase-step request valid |
| step_ready | input | 1 | PLL accepts the step in this cycle |
| step_up | output | 1 | 1 = advance phase, 0 = retard phase |
| step_sel | output | 1 | 0 = measure clock, 1 = resynchronization clock |
| cal_done | output | 1 | Reference phase has been captured |
| ref_phase | output | TAP_BITS | Reference centre tap |
| meas_phase | output | TAP_BITS | Centre tap found by the last sweep without error |
| rs_offset | output | TAP_BITS | Net resync shift applied so far, modulo NTAPS |
| sweep_done | output | 1 | One-cycle pulse at the end of each sweep |
| sweep_err | output | 1 | Last sweep had no usable high run |

## Verification
The sweeps cover several mimic waveforms. A single run centred mid-range sets the reference and shows the no-drift case. Runs shifted one way and then the other show that both step directions and the shorter-path choice are taken. A run that wraps across tap 0 tests the circular search. A drift of exactly half the circle tests the tie rule. A pattern with several runs shows that only the longest one counts. All-low and all-high patterns, one during calibration and one during tracking, show that calibration is retried and that the resync phase is left alone. The PLL model varies its acceptance delay, which exercises the hold-while-waiting rule, and it counts measure and resync steps so that tap return and correction size are observed at the clock port.

// File: rtl/mts_pkg.sv
package mts_pkg;
  typedef enum logic [2:0] {
    ST_SAMPLE,
    ST_MSTEP,
    ST_FIND,
    ST_DECIDE,
    ST_RSTEP,
    ST_WAIT
  } seq_state_t;

  localparam logic SEL_MEAS   = 1'b0;
  localparam logic SEL_RESYNC = 1'b1;
endpackage

// File: rtl/mts_sample_store.sv
module mts_sample_store #(
  parameter int TW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [TW-1:0]        wr_idx,
  input  logic                 wr_bit,
  output logic [(1<<TW)-1:0]   samples
);
  localparam int N = 1 << TW;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        samples[i] <= 1'b0;
      else if (wr_en && (wr_idx == TW'(i)))
        samples[i] <= wr_bit;
    end
  end
endmodule

// File: rtl/mts_centre_finder.sv
module mts_centre_finder #(
  parameter int TW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [(1<<TW)-1:0]   samples,
  output logic                 done,
  output logic [TW-1:0]        centre,
  output logic                 none_high,
  output logic                 all_high
);
  localparam int N = 1 << TW;
  localparam logic [TW:0] KLAST = (TW+1)'(2*N-1);
  localparam logic [TW:0] NCAP  = (TW+1)'(N);

  logic          running;
  logic [TW:0]   k;
  logic [TW:0]   run_len, best_len, len_inc, len_m1;
  logic [TW-1:0] run_start, best_start, start_nx;
  logic          bit_now;

  // scan the ring twice so that a run wrapping past the last tap is seen whole
  assign bit_now  = samples[k[TW-1:0]];
  assign len_inc  = (run_len == NCAP) ? run_len : run_len + (TW+1)'(1);
  assign start_nx = (run_len == '0) ? k[TW-1:0] : run_start;
  assign len_m1   = best_len - (TW+1)'(1);
  assign centre   = best_start + TW'(len_m1 >> 1);
  assign none_high = ~|samples;
  assign all_high  = &samples;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      done       <= 1'b0;
      k          <= '0;
      run_len    <= '0;
      run_start  <= '0;
      best_len   <= '0;
      best_start <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        running    <= 1'b1;
        k          <= '0;
        run_len    <= '0;
        run_start  <= '0;
        best_len   <= '0;
        best_start <= '0;
      end else if (running) begin
        if (bit_now) begin
          run_len   <= len_inc;
          run_start <= start_nx;
          if (len_inc > best_len) begin
            best_len   <= len_inc;
            best_start <= start_nx;
          end
        end else begin
          run_len <= '0;
        end
        if (k == KLAST) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          k <= k + (TW+1)'(1);
        end
      end
    end
  end

  // R4
  scan_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !running);
endmodule

// File: rtl/mts_interval_timer.sv
module mts_interval_timer #(
  parameter int INTERVAL = 6400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic fire
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] TOP = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign fire = en && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!en || fire)
      cnt <= '0;
    else
      cnt <= cnt + CW'(1);
  end

  // R9
  wait_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !en);
endmodule

// File: rtl/mimic_track_seq.sv
module mimic_track_seq
  import mts_pkg::*;
#(
  parameter int TAP_BITS = 4,
  parameter int INTERVAL = 6400000,
  parameter bit KEEP_REF = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mimic_bit,
  output logic                step_valid,
  input  logic                step_ready,
  output logic                step_up,
  output logic                step_sel,
  output logic                cal_done,
  output logic [TAP_BITS-1:0] ref_phase,
  output logic [TAP_BITS-1:0] meas_phase,
  output logic [TAP_BITS-1:0] rs_offset,
  output logic                sweep_done,
  output logic                sweep_err
);
  localparam int NTAPS = 1 << TAP_BITS;
  localparam logic [TAP_BITS-1:0] HALF = TAP_BITS'(NTAPS / 2);
  localparam logic [TAP_BITS-1:0] LAST = TAP_BITS'(NTAPS - 1);
  localparam logic [TAP_BITS-1:0] ONE  = TAP_BITS'(1);

  seq_state_t          state;
  logic [TAP_BITS-1:0] idx, ref_q, meas_q, rs_off_q, rem_q;
  logic                cal_q, done_q, err_q, up_q;
  logic [NTAPS-1:0]    samples;
  logic                fc_go, fc_done, fc_none, fc_full, bad, tm_fire;
  logic [TAP_BITS-1:0] fc_centre, drift, need, mag;
  logic                need_up;

  mts_sample_store #(.TW(TAP_BITS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(state == ST_SAMPLE), .wr_idx(idx), .wr_bit(mimic_bit),
    .samples(samples)
  );

  assign fc_go = (state == ST_MSTEP) && step_ready && (idx == LAST);

  mts_centre_finder #(.TW(TAP_BITS)) u_find (
    .clk(clk), .rst_n(rst_n), .go(fc_go), .samples(samples),
    .done(fc_done), .centre(fc_centre),
    .none_high(fc_none), .all_high(fc_full)
  );

  mts_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(state == ST_WAIT), .fire(tm_fire)
  );

  // correction size and direction, shortest way round the tap ring
  assign bad     = fc_none || fc_full;
  assign drift   = fc_centre - ref_q;
  assign need    = KEEP_REF ? (drift - rs_off_q) : drift;
  assign need_up = (need <= HALF);
  assign mag     = need_up ? need : (TAP_BITS'(0) - need);

  assign step_valid = (state == ST_MSTEP) || (state == ST_RSTEP);
  assign step_sel   = (state == ST_RSTEP) ? SEL_RESYNC : SEL_MEAS;
  assign step_up    = (state == ST_RSTEP) ? up_q : 1'b1;

  assign cal_done   = cal_q;
  assign ref_phase  = ref_q;
  assign meas_phase = meas_q;
  assign rs_offset  = rs_off_q;
  assign sweep_done = done_q;
  assign sweep_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SAMPLE;
      idx      <= '0;
      cal_q    <= 1'b0;
      ref_q    <= '0;
      meas_q   <= '0;
      rs_off_q <= '0;
      rem_q    <= '0;
      up_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_SAMPLE: state <= ST_MSTEP;
        ST_MSTEP: begin
          if (step_ready) begin
            if (idx == LAST) begin
              idx   <= '0;
              state <= ST_FIND;
            end else begin
              idx   <= idx + ONE;
              state <= ST_SAMPLE;
            end
          end
        end
        ST_FIND: if (fc_done) state <= ST_DECIDE;
        ST_DECIDE: begin
          done_q <= 1'b1;
          err_q  <= bad;
          state  <= ST_WAIT;
          if (!bad) begin
            meas_q <= fc_centre;
            if (!cal_q) begin
              ref_q <= fc_centre;
              cal_q <= 1'b1;
            end else if (need != '0) begin
              rem_q <= mag;
              up_q  <= need_up;
              state <= ST_RSTEP;
              if (!KEEP_REF) ref_q <= fc_centre;
            end
          end
        end
        ST_RSTEP: begin
          if (step_ready) begin
            rs_off_q <= up_q ? rs_off_q + ONE : rs_off_q - ONE;
            if (rem_q == ONE) state <= ST_WAIT;
            else              rem_q <= rem_q - ONE;
          end
        end
        ST_WAIT: if (tm_fire) state <= ST_SAMPLE;
        default: state <= ST_SAMPLE;
      endcase
    end
  end

  // R3
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !step_ready) |=> (step_valid && $stable(step_up) && $stable(step_sel)));

  // R5
  resync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |-> !(step_valid && step_sel));

  // R6
  offset_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_valid && step_sel && step_ready) |=> $stable(rs_offset));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_done && sweep_err) |=> !(step_valid && step_sel));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !sweep_done);
endmodule

// File: tb/sim_mimic_track_seq.sv
module sim_mimic_track_seq;
  localparam int TB = 4;
  localparam int N  = 16;
  localparam int IV = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mimic_bit, step_valid, step_up, step_sel;
  logic cal_done, sweep_done, sweep_err;
  logic [TB-1:0] ref_phase, meas_phase, rs_offset;
  logic rdy = 1'b0;
  logic [N-1:0] pat = '0;

  int meas_tap = 0, rs_tap = 0;
  int mcount = 0, upcount = 0, dncount = 0;
  int dly = 0, dseq = 0, hold_bad = 0;
  bit prev_wait = 0, w_up = 0, w_sel = 0, p_up = 0, p_sel = 0;
  int vectors = 0, errors = 0;
  bit finished = 0;
  int ref_e = 0, app_e = 0;
  bit cal_e = 0;

  typedef struct { bit err; int centre; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  assign mimic_bit = pat[meas_tap];

  mimic_track_seq #(.TAP_BITS(TB), .INTERVAL(IV), .KEEP_REF(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .mimic_bit(mimic_bit),
    .step_valid(step_valid), .step_ready(rdy), .step_up(step_up), .step_sel(step_sel),
    .cal_done(cal_done), .ref_phase(ref_phase), .meas_phase(meas_phase),
    .rs_offset(rs_offset), .sweep_done(sweep_done), .sweep_err(sweep_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // PLL model: accepts after a varying delay, applies the step half a cycle after the transfer
  always @(negedge clk) begin
    if (rdy) begin
      if (!p_sel) begin
        meas_tap = p_up ? (meas_tap + 1) % N : (meas_tap + N - 1) % N;
        mcount++;
      end else if (p_up) begin
        rs_tap = (rs_tap + 1) % N;
        upcount++;
      end else begin
        rs_tap = (rs_tap + N - 1) % N;
        dncount++;
      end
      rdy = 1'b0;
      prev_wait = 0;
    end else if (step_valid) begin
      if (prev_wait && ((step_up !== w_up) || (step_sel !== w_sel))) hold_bad++;
      prev_wait = 1;
      w_up = step_up;
      w_sel = step_sel;
      if (dly == 0) begin
        rdy = 1'b1;
        p_up = step_up;
        p_sel = step_sel;
        dseq = (dseq + 1) % 3;
        dly = dseq;
      end else begin
        dly--;
      end
    end else begin
      prev_wait = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && sweep_done) begin
      if (q.size() == 0) begin
        chk("R11 unexpected sweep_done", 1, 0);
      end else begin
        e = q.pop_front();
        chk("R8 sweep error flag", int'(sweep_err), int'(e.err));
        if (!e.err) chk("R4 centre of longest high run", int'(meas_phase), e.centre);
      end
    end
  end

  function automatic int centre_of(input logic [N-1:0] p);
    int best = 0, bs = 0;
    for (int s = 0; s < N; s++) begin
      if (p[s] && !p[(s + N - 1) % N]) begin
        int len;
        len = 0;
        while (len < N && p[(s + len) % N]) len++;
        if (len > best) begin
          best = len;
          bs = s;
        end
      end
    end
    return (bs + (best - 1) / 2) % N;
  endfunction

  task automatic run_sweep(input logic [N-1:0] p, input bit chk_iv);
    bit bad;
    int c, need, n, eu, ed;
    string tag;
    pat = p;
    mcount = 0; upcount = 0; dncount = 0;
    eu = 0; ed = 0;
    bad = (p == '0) || (&p);
    c = bad ? 0 : centre_of(p);
    q.push_back('{bad, c});
    @(negedge clk);
    while (!sweep_done) @(negedge clk);
    chk("R2 measure steps in sweep", mcount, N);
    chk("R2 measure tap back at start", meas_tap, 0);
    if (!bad) begin
      if (!cal_e) begin
        cal_e = 1;
        ref_e = c;
      end else begin
        need = (c - ref_e - app_e + 3 * N) % N;
        if (need != 0 && need <= N / 2) begin
          eu = need;
          app_e = (app_e + need) % N;
        end else if (need != 0) begin
          ed = N - need;
          app_e = (app_e + need) % N;
        end
      end
    end
    @(negedge clk);
    chk("R11 sweep_done one cycle", int'(sweep_done), 0);
    repeat (59) @(negedge clk);
    chk("R5 calibration done flag", int'(cal_done), int'(cal_e));
    chk("R10 reference phase held", int'(ref_phase), ref_e);
    tag = bad ? "R8 resync untouched on error" :
          ((eu == 0 && ed == 0) ? "R7 no correction when equal" : "R6 resync correction");
    chk({tag, " (offset port)"}, int'(rs_offset), app_e);
    chk({tag, " (PLL resync tap)"}, rs_tap, app_e);
    chk({tag, " (up steps)"}, upcount, eu);
    chk({tag, " (down steps)"}, dncount, ed);
    if (chk_iv) begin
      n = 60;
      while (!step_valid) begin
        @(negedge clk);
        n++;
      end
      chk("R9 sweep interval", n, IV + 1);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    pat = '0;
    repeat (5) @(negedge clk);
    chk("R1 step_valid in reset", int'(step_valid), 0);
    chk("R1 cal_done in reset", int'(cal_done), 0);
    chk("R1 sweep_done in reset", int'(sweep_done), 0);
    chk("R1 sweep_err in reset", int'(sweep_err), 0);
    chk("R1 rs_offset in reset", int'(rs_offset), 0);
    rst_n = 1'b1;
    run_sweep(16'b0000_0000_0000_0000, 0);  // calibration fails, R8
    run_sweep(16'b0000_0011_1111_0000, 1);  // calibrates at 6, R5
    run_sweep(16'b0000_0011_1111_0000, 0);  // no drift, R7
    run_sweep(16'b0001_1111_1000_0000, 0);  // centre 9: up 3
    run_sweep(16'b0000_0000_0111_1110, 0);  // centre 3: down 6
    run_sweep(16'b1100_0000_0000_1111, 0);  // wrapping run, centre 0: down 3
    run_sweep(16'b0000_0111_1100_0000, 0);  // centre 8: half circle, up 8
    run_sweep(16'b1111_1111_1111_1111, 0);  // all high, R8
    run_sweep(16'b0111_1110_0001_1001, 0);  // several runs, centre 11: up 3
    run_sweep(16'b1000_0000_1100_0111, 0);  // wrap longest, centre 0: up 5
    chk("R3 request held while waiting", hold_bad, 0);
    chk("R4 every sweep reported", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      errors++;
      $display("FAIL R2 watchdog: actual %0d cycles expected all sweeps completed", 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule